// File: doc/BRIEF.md
# Dual-Level Interrupt Acceptance Controller

This block sits beside the sequencer of an 8-bit processor core. At the end of each instruction it decides whether the core takes a non-maskable interrupt, a maskable interrupt, or goes on to the next instruction. It holds the state behind that decision: the two interrupt-enable flip-flops, a latch that remembers a falling edge on the non-maskable request, a one-instruction shadow that delays the effect of an enable, and the selected maskable vector mode.

The core's decoder gives the block single-cycle pulses for enable, disable, the two return-from-interrupt forms and mode selection. Each pulse arrives together with the instruction-end strobe of the instruction that produced it. The take outputs are combinational and appear in that same strobe cycle. The vector outputs give the core the address it needs. For the non-maskable interrupt this is a fixed entry point. In mode 1 it is a fixed restart address. In mode 2 it is a table pointer built from the page register and the acknowledging device's byte. In mode 0 the vector is zero, and the core executes the device's byte as an instruction. The saved enable bit is always available, so the core can copy it into its parity/overflow flag when it loads the accumulator from the page or refresh register.

Top module: `irq_accept_ctrl`

## Requirements
- R1: A high-to-low transition on `nmi_n` sets the pending latch at the clock edge where it is sampled. The latch is taken at the next `insn_end` cycle and then cleared. If `nmi_n` stays low, it is not taken a second time.
- R2: `take_int` is high only in an `insn_end` cycle in which `int_n` is low, `busreq_n` is high, IFF1 is 1 and no non-maskable interrupt is pending.
- R3: If both requests are pending at the same boundary, only `take_nmi` rises. The maskable request is left waiting and is taken at a later boundary once it is enabled again.
- R4: Taking the non-maskable interrupt copies IFF1 into IFF2 and clears IFF1, and `vec_addr` reads 0x0066 in that cycle. A RETN pulse copies IFF2 back into IFF1.
- R5: Reset, a DI pulse and taking a maskable interrupt each clear both flip-flops. An EI pulse sets both. `ie_save` always shows IFF2.
- R6: A maskable request is not taken at the end of an EI instruction, nor at the end of the instruction that follows it. It can be taken at the boundary after that.
- R7: Reset selects mode 0. An `op_im` pulse with `im_sel` of 0, 1 or 2 selects that mode, and `im_sel` = 3 leaves the mode unchanged. With no non-maskable interrupt pending, `vec_addr` is 0x0000 in mode 0 and 0x0038 in mode 1.
- R8: In mode 2, `vec_addr` = {`page_reg`, `ack_vec`[7:1], 0}. `vec_addr_hi` = `vec_addr` + 1 is the address of the handler's high byte.
- R9: Decode pulses have no effect while `insn_end` is low. A RETI pulse leaves both flip-flops unchanged.
- R10: `take_nmi` and `take_int` are never high together, and neither is high outside an `insn_end` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| int_n | input | 1 | Maskable request, active low, level sensitive |
| busreq_n | input | 1 | Bus request from another master, active low |
| insn_end | input | 1 | High during the last clock of each instruction |
| op_ei | input | 1 | Enable-interrupts pulse |
| op_di | input | 1 | Disable-interrupts pulse |
| op_retn | input | 1 | Return-from-non-maskable pulse |
| op_reti | input | 1 | Return-from-maskable pulse |
| op_im | input | 1 | Mode-select pulse |
| im_sel | input | 2 | Mode requested with `op_im` |
| page_reg | input | 8 | Interrupt page register, high byte of the mode 2 pointer |
| ack_vec | input | 8 | Byte supplied by the device during acknowledge |
| take_nmi | output | 1 | Take the non-maskable interrupt now |
| take_int | output | 1 | Take the maskable interrupt now |
| int_mode | output | 2 | Current maskable mode |
| vec_addr | output | 16 | Entry address, or mode 2 table pointer |
| vec_addr_hi | output | 16 | Mode 2 pointer plus one |
| ie_save | output | 1 | IFF2, for copying into the parity/overflow flag |

## Verification
The hardest states to reach are those where an enable decision is pending across instruction boundaries. One is the one-instruction shadow after EI while a maskable request is already held low. Another is a non-maskable edge that arrives while a maskable request is waiting, followed by the RETN that reopens the maskable path. The stimulus gets there by keeping `int_n` low through sequences of boundary strobes: EI, an ordinary instruction, then a third boundary. A falling edge is placed on `nmi_n` one clock before a strobe, so the pending latch and the maskable level meet at the same boundary. IFF1 has no port of its own, so it is observed through whether `take_int` rises.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
   typedef enum logic [1:0] {
      IM_FETCH = 2'd0,
      IM_FIXED = 2'd1,
      IM_TABLE = 2'd2
   } im_mode_t;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_n,
   input  logic clr,
   output logic pend
);
   logic nmi_s;
   logic prev_q;
   logic fall;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign nmi_s = nmi_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], nmi_n};
         end
         assign nmi_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   assign fall = prev_q & ~nmi_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         pend   <= 1'b0;
      end else begin
         prev_q <= nmi_s;
         if (fall)     pend <= 1'b1;
         else if (clr) pend <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_enable_ff.sv
module irq_enable_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic op_ei,
   input  logic op_di,
   input  logic op_retn,
   input  logic take_nmi,
   input  logic take_int,
   output logic iff1,
   output logic iff2,
   output logic ei_hold
);
   logic n1, n2, a1, a2;

   always_comb begin
      a1 = iff1;
      a2 = iff2;
      if (step) begin
         if (op_di) begin
            a1 = 1'b0;
            a2 = 1'b0;
         end else if (op_ei) begin
            a1 = 1'b1;
            a2 = 1'b1;
         end else if (op_retn) begin
            a1 = iff2;
         end
      end
      n1 = a1;
      n2 = a2;
      if (take_nmi) begin
         n2 = a1;
         n1 = 1'b0;
      end else if (take_int) begin
         n1 = 1'b0;
         n2 = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iff1    <= 1'b0;
         iff2    <= 1'b0;
         ei_hold <= 1'b0;
      end else begin
         iff1 <= n1;
         iff2 <= n2;
         if (step) ei_hold <= op_ei;
      end
   end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
   import irq_accept_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int          DATA_W   = 8,
   parameter logic [15:0] NMI_VEC  = 16'h0066,
   parameter logic [15:0] RST1_VEC = 16'h0038
) (
   input  im_mode_t          mode,
   input  logic              nmi_sel,
   input  logic [DATA_W-1:0] page,
   input  logic [DATA_W-1:0] dev_byte,
   output logic [ADDR_W-1:0] vec_lo,
   output logic [ADDR_W-1:0] vec_hi
);
   localparam int PTR_W = 2 * DATA_W;
   logic [PTR_W-1:0] tbl_ptr;

   assign tbl_ptr = {page, dev_byte[DATA_W-1:1], 1'b0};

   always_comb begin
      if (nmi_sel)              vec_lo = ADDR_W'(NMI_VEC);
      else if (mode == IM_FIXED) vec_lo = ADDR_W'(RST1_VEC);
      else if (mode == IM_TABLE) vec_lo = ADDR_W'(tbl_ptr);
      else                       vec_lo = '0;
   end

   assign vec_hi = vec_lo + ADDR_W'(1);
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
   import irq_accept_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter int          DATA_W      = 8,
   parameter int          SYNC_STAGES = 0,
   parameter logic [15:0] NMI_VEC     = 16'h0066,
   parameter logic [15:0] RST1_VEC    = 16'h0038
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_n,
   input  logic              int_n,
   input  logic              busreq_n,
   input  logic              insn_end,
   input  logic              op_ei,
   input  logic              op_di,
   input  logic              op_retn,
   input  logic              op_reti,
   input  logic              op_im,
   input  logic [1:0]        im_sel,
   input  logic [DATA_W-1:0] page_reg,
   input  logic [DATA_W-1:0] ack_vec,
   output logic              take_nmi,
   output logic              take_int,
   output logic [1:0]        int_mode,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [ADDR_W-1:0] vec_addr_hi,
   output logic              ie_save
);
   generate
      if (ADDR_W < 2 * DATA_W) begin : g_bad_width
         $error("ADDR_W must hold page and vector byte");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic     nmi_pend;
   logic     iff1, iff2, ei_hold;
   im_mode_t mode_q;
   logic     unused_reti;

   // RETI needs no action here: it is accepted and leaves the flip-flops alone
   assign unused_reti = op_reti;

   nmi_edge_latch #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
      .clk   (clk),
      .rst_n (rst_n),
      .nmi_n (nmi_n),
      .clr   (take_nmi),
      .pend  (nmi_pend)
   );

   assign take_nmi = insn_end & nmi_pend;
   assign take_int = insn_end & ~nmi_pend & ~int_n & busreq_n & iff1
                   & ~ei_hold & ~op_ei & ~op_di;

   irq_enable_ff u_iff (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (insn_end),
      .op_ei    (op_ei),
      .op_di    (op_di),
      .op_retn  (op_retn),
      .take_nmi (take_nmi),
      .take_int (take_int),
      .iff1     (iff1),
      .iff2     (iff2),
      .ei_hold  (ei_hold)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= IM_FETCH;
      end else if (insn_end && op_im && im_sel != 2'd3) begin
         mode_q <= im_mode_t'(im_sel);
      end
   end

   irq_vector_gen #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NMI_VEC  (NMI_VEC),
      .RST1_VEC (RST1_VEC)
   ) u_vec (
      .mode     (mode_q),
      .nmi_sel  (nmi_pend),
      .page     (page_reg),
      .dev_byte (ack_vec),
      .vec_lo   (vec_addr),
      .vec_hi   (vec_addr_hi)
   );

   assign int_mode = mode_q;
   assign ie_save  = iff2;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
   parameter int          ADDR_W  = 16,
   parameter logic [15:0] NMI_VEC = 16'h0066
) (
   input logic              clk,
   input logic              rst_n,
   input logic              insn_end,
   input logic              take_nmi,
   input logic              take_int,
   input logic              op_ei,
   input logic              op_di,
   input logic              op_retn,
   input logic              iff1,
   input logic              iff2,
   input logic [ADDR_W-1:0] vec_addr
);
   AST_TAKE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(take_nmi && take_int)); // R10
   AST_TAKE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      (take_nmi || take_int) |-> insn_end); // R10
   AST_INT_NEEDS_IFF1: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> iff1); // R2
   AST_INT_CLEARS_IFF: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |=> (!iff1 && !iff2)); // R5
   AST_NMI_SAVES_IFF: assert property (@(posedge clk) disable iff (!rst_n)
      (take_nmi && !op_ei && !op_di && !op_retn) |=> (!iff1 && iff2 == $past(iff1))); // R4
   AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      take_nmi |-> vec_addr == ADDR_W'(NMI_VEC)); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_end |=> ($stable(iff1) && $stable(iff2))); // R9
endmodule

bind irq_accept_ctrl irq_accept_chk #(.ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .insn_end (insn_end),
   .take_nmi (take_nmi),
   .take_int (take_int),
   .op_ei    (op_ei),
   .op_di    (op_di),
   .op_retn  (op_retn),
   .iff1     (iff1),
   .iff2     (iff2),
   .vec_addr (vec_addr)
);

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic nmi_n = 1'b1, int_n = 1'b1, busreq_n = 1'b1, insn_end = 1'b0;
   logic op_ei = 0, op_di = 0, op_retn = 0, op_reti = 0, op_im = 0;
   logic [1:0] im_sel = 2'd0;
   logic [7:0] page_reg = 8'h00, ack_vec = 8'h00;
   logic take_nmi, take_int, ie_save;
   logic [1:0] int_mode;
   logic [15:0] vec_addr, vec_addr_hi;

   int n_chk = 0, n_bad = 0;
   logic s_tn, s_ti;
   logic [15:0] s_vec, s_vhi;

   always #4 clk = ~clk;

   irq_accept_ctrl dut (
      .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .int_n(int_n), .busreq_n(busreq_n),
      .insn_end(insn_end), .op_ei(op_ei), .op_di(op_di), .op_retn(op_retn),
      .op_reti(op_reti), .op_im(op_im), .im_sel(im_sel), .page_reg(page_reg),
      .ack_vec(ack_vec), .take_nmi(take_nmi), .take_int(take_int),
      .int_mode(int_mode), .vec_addr(vec_addr), .vec_addr_hi(vec_addr_hi),
      .ie_save(ie_save)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one instruction boundary; kind: 0 none,1 EI,2 DI,3 RETN,4 RETI,5 IM
   task automatic boundary(input int kind, input logic [1:0] sel);
      @(negedge clk);
      insn_end = 1'b1;
      op_ei = (kind == 1); op_di = (kind == 2); op_retn = (kind == 3);
      op_reti = (kind == 4); op_im = (kind == 5); im_sel = sel;
      #1;
      s_tn = take_nmi; s_ti = take_int; s_vec = vec_addr; s_vhi = vec_addr_hi;
      @(posedge clk); #1;
      insn_end = 0; op_ei = 0; op_di = 0; op_retn = 0; op_reti = 0; op_im = 0;
   endtask

   task automatic nmi_fall();
      @(negedge clk); nmi_n = 1'b0;
   endtask

   task automatic enable_clean();
      int_n = 1'b1;
      boundary(1, 0); boundary(0, 0); boundary(0, 0);
   endtask

   task automatic t_reset();
      check("R5 reset ie_save", ie_save, 0);
      check("R7 reset mode", int_mode, 0);
      check("R7 mode0 vec", vec_addr, 16'h0000);
      int_n = 1'b0;
      boundary(0, 0);
      check("R2 masked at reset", s_ti, 0);
      check("R10 no nmi", s_tn, 0);
      int_n = 1'b1;
   endtask

   task automatic t_ei_delay();
      int_n = 1'b0;
      boundary(1, 0);
      check("R6 not at EI end", s_ti, 0);
      check("R5 EI sets", ie_save, 1);
      boundary(0, 0);
      check("R6 not after next insn", s_ti, 0);
      boundary(0, 0);
      check("R2 taken", s_ti, 1);
      check("R5 take clears", ie_save, 0);
      boundary(0, 0);
      check("R5 no retake after clear", s_ti, 0);
      int_n = 1'b1;
   endtask

   task automatic t_busreq();
      enable_clean();
      int_n = 1'b0; busreq_n = 1'b0;
      boundary(0, 0);
      check("R2 busreq blocks", s_ti, 0);
      busreq_n = 1'b1;
      boundary(0, 0);
      check("R2 busreq released", s_ti, 1);
      int_n = 1'b1;
   endtask

   task automatic t_di();
      enable_clean();
      boundary(2, 0);
      check("R5 DI clears", ie_save, 0);
      int_n = 1'b0;
      boundary(0, 0);
      check("R5 DI masks", s_ti, 0);
      int_n = 1'b1;
   endtask

   task automatic t_nmi();
      enable_clean();
      nmi_fall();
      boundary(0, 0);
      check("R1 nmi taken", s_tn, 1);
      check("R4 nmi vector", s_vec, 16'h0066);
      check("R4 iff2 saved", ie_save, 1);
      int_n = 1'b0;
      boundary(0, 0);
      check("R1 held low not retaken", s_tn, 0);
      check("R4 iff1 cleared", s_ti, 0);
      boundary(3, 0);
      check("R4 retn cycle", s_ti, 0);
      boundary(0, 0);
      check("R4 retn restores", s_ti, 1);
      int_n = 1'b1; nmi_n = 1'b1;
      // nmi with enables off: iff2 gets 0
      boundary(0, 0);
      nmi_fall();
      boundary(0, 0);
      check("R1 second edge taken", s_tn, 1);
      check("R4 iff2 copies zero", ie_save, 0);
      nmi_n = 1'b1;
   endtask

   task automatic t_prio();
      enable_clean();
      int_n = 1'b0;
      nmi_fall();
      boundary(0, 0);
      check("R3 nmi wins", s_tn, 1);
      check("R3 int held off", s_ti, 0);
      boundary(3, 0);
      boundary(0, 0);
      check("R3 int later", s_ti, 1);
      check("R10 single take", s_tn, 0);
      int_n = 1'b1; nmi_n = 1'b1;
      boundary(0, 0);
   endtask

   task automatic t_modes();
      boundary(5, 2'd1);
      check("R7 mode1", int_mode, 1);
      check("R7 mode1 vec", vec_addr, 16'h0038);
      enable_clean();
      int_n = 1'b0;
      boundary(0, 0);
      check("R7 mode1 take vec", s_vec, 16'h0038);
      int_n = 1'b1;
      page_reg = 8'h12; ack_vec = 8'h35;
      boundary(5, 2'd2);
      #1;
      check("R8 table ptr", vec_addr, 16'h1234);
      check("R8 table ptr hi", vec_addr_hi, 16'h1235);
      boundary(5, 2'd3);
      check("R7 sel3 ignored", int_mode, 2);
      boundary(5, 2'd0);
      check("R7 mode0 again", vec_addr, 16'h0000);
   endtask

   task automatic t_gating();
      boundary(2, 0);
      @(negedge clk); op_ei = 1'b1; @(negedge clk); op_ei = 1'b0; #1;
      check("R9 EI without end ignored", ie_save, 0);
      enable_clean();
      boundary(4, 0);
      check("R9 RETI keeps iff2", ie_save, 1);
      int_n = 1'b0;
      boundary(0, 0);
      check("R9 RETI keeps iff1", s_ti, 1);
      int_n = 1'b1;
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      t_reset();
      t_ei_delay();
      t_busreq();
      t_di();
      t_nmi();
      t_prio();
      t_modes();
      t_gating();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule